// File: doc/BRIEF.md
# Shared-Memory Write Conflict Resolver

The block models one lockstep access step of a group of requesters against a small bank of shared cells. Every clock is one access step. In each step each requester may read one cell and may write one cell. All reads see the bank as it stood before the step. The writes are then merged into the bank under the selected concurrency policy. The bank is a register array, and its whole contents are visible on an output bus.

A three-bit `mode` input picks how simultaneous accesses to the same cell are treated. The choices are: strict exclusivity for both reads and writes, shared reads with exclusive writes, writes that merge only when their values agree, writes that pick one writer in rotation, and writes that pick the lowest-numbered writer. A registered `violation` flag reports a collision that the chosen policy forbids. The forbidden write is dropped.

Top module: `conflict_resolver`

## Requirements
- R1: While `rst_n` is low, every cell, every `rd_data` lane and `violation` are zero, and the rotation pointer is 0.
- R2: After a clock edge at which requester r had `rd_en` set, `rd_data` lane r holds the value that its addressed cell had before that edge's writes. A lane whose `rd_en` was clear reads zero.
- R3: A cell written by exactly one requester takes that requester's data in every mode. A cell that no requester writes keeps its value.
- R4: Mode 0 (exclusive read, exclusive write) raises `violation` when two or more requesters read one cell, or when two or more write one cell. The colliding writes are dropped and the cell is unchanged.
- R5: Mode 1 (concurrent read, exclusive write) never flags shared reads. Two or more writers to one cell raise `violation` and leave the cell unchanged.
- R6: Mode 2 (common) commits colliding writes without a flag when all their values are equal. If the values differ, it raises `violation` and leaves the cell unchanged.
- R7: Mode 4 (priority) commits the data of the lowest-indexed writer of each cell and never raises `violation`.
- R8: Mode 3 (arbitrary) commits the first writer found at or after the rotation pointer, scanning upward with wraparound. It never raises `violation`. The pointer advances by one, wrapping at NREQ, after every mode-3 step in which any cell has two or more writers.
- R9: Mode values 5, 6 and 7 behave exactly like mode 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one access step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Concurrency policy: 0 excl/excl, 1 shared-read, 2 common, 3 arbitrary, 4 priority |
| rd_en | input | NREQ | Per-requester read request |
| wr_en | input | NREQ | Per-requester write request |
| addr | input | NREQ*log2(NCELL) | Per-requester cell index, requester r in slice r |
| wdata | input | NREQ*DW | Per-requester write data, requester r in slice r |
| mem_out | output | NCELL*DW | Current bank contents, cell c in slice c |
| rd_data | output | NREQ*DW | Registered read results, requester r in slice r |
| violation | output | 1 | Registered flag for a forbidden collision in the last step |

## Verification
The assertions assume that every input is a settled, known value at each rising edge. They also assume that a requester's single address serves both its read and its write, so a read lane always refers to the cell named on `addr` in the same step. They place no limit on how many requesters may aim at one cell. The stimulus changes inputs only on falling edges. It sweeps all eight mode codes, every write-enable pattern, a set of read-enable patterns and folded address patterns that cover every cell. The write data is arranged so that colliding writers agree in some steps and disagree in others.

// File: rtl/wcr_pkg.sv
package wcr_pkg;
    typedef enum logic [2:0] {
        POL_EXCL   = 3'd0,
        POL_SHRD   = 3'd1,
        POL_COMMON = 3'd2,
        POL_ANY    = 3'd3,
        POL_RANK   = 3'd4
    } policy_e;
endpackage

// File: rtl/wcr_cell_arbiter.sv
module wcr_cell_arbiter
    import wcr_pkg::*;
#(
    parameter int NREQ = 4,
    parameter int DW   = 8,
    parameter int PW   = 2
) (
    input  logic [2:0]         mode,
    input  logic [NREQ-1:0]    rd_hit,
    input  logic [NREQ-1:0]    wr_hit,
    input  logic [NREQ*DW-1:0] wdata,
    input  logic [PW-1:0]      rr_ptr,
    input  logic [DW-1:0]      cur_val,
    output logic [DW-1:0]      nxt_val,
    output logic               conflict,
    output logic               collide
);
    logic [DW-1:0] low_d;
    logic [DW-1:0] rot_d;
    logic          low_found;
    logic          rot_found;
    logic          all_same;
    logic          many_rd;
    logic          many_wr;
    logic          any_wr;

    // Lowest-index writer and agreement of all writers
    always_comb begin
        low_found = 1'b0;
        low_d     = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (wr_hit[i] && !low_found) begin
                low_found = 1'b1;
                low_d     = wdata[i*DW +: DW];
            end
        end
        all_same = 1'b1;
        for (int i = 0; i < NREQ; i++) begin
            if (wr_hit[i] && (wdata[i*DW +: DW] != low_d)) all_same = 1'b0;
        end
    end

    // First writer at or after the rotation pointer, wrapping
    always_comb begin
        rot_found = 1'b0;
        rot_d     = '0;
        for (int k = 0; k < NREQ; k++) begin
            int idx;
            idx = (int'(rr_ptr) + k) % NREQ;
            if (wr_hit[idx] && !rot_found) begin
                rot_found = 1'b1;
                rot_d     = wdata[idx*DW +: DW];
            end
        end
    end

    always_comb begin
        many_rd  = ($countones(rd_hit) > 1);
        many_wr  = ($countones(wr_hit) > 1);
        any_wr   = |wr_hit;
        nxt_val  = cur_val;
        conflict = 1'b0;
        collide  = many_wr;
        case (policy_e'(mode))
            POL_EXCL: begin
                conflict = many_rd || many_wr;
                if (any_wr && !many_wr) nxt_val = low_d;
            end
            POL_SHRD: begin
                conflict = many_wr;
                if (any_wr && !many_wr) nxt_val = low_d;
            end
            POL_COMMON: begin
                conflict = many_wr && !all_same;
                if (any_wr && all_same) nxt_val = low_d;
            end
            POL_ANY: begin
                if (rot_found) nxt_val = rot_d;
            end
            default: begin
                if (any_wr) nxt_val = low_d;
            end
        endcase
    end
endmodule

// File: rtl/wcr_read_port.sv
module wcr_read_port #(
    parameter int NCELL = 4,
    parameter int DW    = 8,
    parameter int AW    = 2
) (
    input  logic                rd_en,
    input  logic [AW-1:0]       addr,
    input  logic [NCELL*DW-1:0] bank,
    output logic [DW-1:0]       data
);
    always_comb begin
        data = '0;
        if (rd_en) data = bank[int'(addr)*DW +: DW];
    end
endmodule

// File: rtl/conflict_resolver.sv
module conflict_resolver #(
    parameter int NREQ  = 4,
    parameter int NCELL = 4,
    parameter int DW    = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [2:0]                      mode,
    input  logic [NREQ-1:0]                 rd_en,
    input  logic [NREQ-1:0]                 wr_en,
    input  logic [NREQ*$clog2(NCELL)-1:0]   addr,
    input  logic [NREQ*DW-1:0]              wdata,
    output logic [NCELL*DW-1:0]             mem_out,
    output logic [NREQ*DW-1:0]              rd_data,
    output logic                            violation
);
    localparam int AW = $clog2(NCELL);
    localparam int PW = $clog2(NREQ);
    localparam logic [PW-1:0] RR_LAST = PW'(NREQ - 1);

    typedef struct packed {
        logic [NCELL-1:0][DW-1:0] mem;
        logic [NREQ-1:0][DW-1:0]  rdat;
        logic                     viol;
        logic [PW-1:0]            rr;
    } state_t;

    state_t st_d, st_q;

    logic [NCELL-1:0][NREQ-1:0] rd_hit;
    logic [NCELL-1:0][NREQ-1:0] wr_hit;
    logic [NCELL-1:0][DW-1:0]   cell_val;
    logic [NCELL-1:0]           cell_conf;
    logic [NCELL-1:0]           cell_coll;
    logic [NREQ-1:0][DW-1:0]    lane_val;
    logic [NCELL*DW-1:0]        bank_flat;

    assign bank_flat = st_q.mem;

    always_comb begin
        for (int c = 0; c < NCELL; c++) begin
            for (int r = 0; r < NREQ; r++) begin
                rd_hit[c][r] = rd_en[r] && (int'(addr[r*AW +: AW]) == c);
                wr_hit[c][r] = wr_en[r] && (int'(addr[r*AW +: AW]) == c);
            end
        end
    end

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        wcr_cell_arbiter #(.NREQ(NREQ), .DW(DW), .PW(PW)) i_arb (
            .mode     (mode),
            .rd_hit   (rd_hit[c]),
            .wr_hit   (wr_hit[c]),
            .wdata    (wdata),
            .rr_ptr   (st_q.rr),
            .cur_val  (st_q.mem[c]),
            .nxt_val  (cell_val[c]),
            .conflict (cell_conf[c]),
            .collide  (cell_coll[c])
        );
    end

    for (genvar r = 0; r < NREQ; r++) begin : g_lane
        wcr_read_port #(.NCELL(NCELL), .DW(DW), .AW(AW)) i_rd (
            .rd_en (rd_en[r]),
            .addr  (addr[r*AW +: AW]),
            .bank  (bank_flat),
            .data  (lane_val[r])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.mem  = cell_val;
        st_d.rdat = lane_val;
        st_d.viol = |cell_conf;
        if ((mode == 3'd3) && (|cell_coll)) begin
            st_d.rr = (st_q.rr == RR_LAST) ? '0 : st_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_out   = st_q.mem;
    assign rd_data   = st_q.rdat;
    assign violation = st_q.viol;
endmodule

// File: rtl/wcr_checker.sv
module wcr_checker #(
    parameter int NREQ  = 4,
    parameter int NCELL = 4,
    parameter int DW    = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [2:0]                    mode,
    input logic [NREQ-1:0]               rd_en,
    input logic [NREQ-1:0]               wr_en,
    input logic [NREQ*$clog2(NCELL)-1:0] addr,
    input logic [NCELL*DW-1:0]           mem_out,
    input logic [NREQ*DW-1:0]            rd_data,
    input logic                          violation
);
    localparam int AW = $clog2(NCELL);
    logic [DW-1:0] cell_at_lane0;
    assign cell_at_lane0 = mem_out[int'(addr[AW-1:0])*DW +: DW];

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0) |=> $stable(mem_out));

    p_read_old_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en[0] |=> (rd_data[DW-1:0] == $past(cell_at_lane0)));

    p_read_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en[0] |=> (rd_data[DW-1:0] == '0));

    p_shared_reads_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd1) && (wr_en == '0)) |=> !violation);

    p_rank_no_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode >= 3'd4) |=> !violation);

    p_rotate_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3) |=> !violation);
endmodule

bind conflict_resolver wcr_checker #(.NREQ(NREQ), .NCELL(NCELL), .DW(DW)) u_wcr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .mem_out   (mem_out),
    .rd_data   (rd_data),
    .violation (violation)
);

// File: tb/test_conflict_resolver.sv
module test_conflict_resolver;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int C  = 4;
    localparam int W  = 8;
    localparam int AW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2:0]     mode = '0;
    logic [N-1:0]   rd_en = '0;
    logic [N-1:0]   wr_en = '0;
    logic [N*AW-1:0] addr = '0;
    logic [N*W-1:0] wdata = '0;
    logic [C*W-1:0] mem_out;
    logic [N*W-1:0] rd_data;
    logic           violation;

    int n_checks = 0;
    int n_fails  = 0;
    int mem_m [C];
    int rr_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conflict_resolver #(.NREQ(N), .NCELL(C), .DW(W)) i_conflict_resolver (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .mem_out(mem_out), .rd_data(rd_data),
        .violation(violation)
    );

    function automatic string tag_of(int md);
        case (md)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R8";
            4: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string req, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(int md, logic [N-1:0] re, logic [N-1:0] we,
                        logic [N*AW-1:0] ad, logic [N*W-1:0] wd, string mtag);
        int exp_rd [N];
        int exp_mem [C];
        bit exp_v;
        bit coll;
        @(negedge clk);
        mode = 3'(md); rd_en = re; wr_en = we; addr = ad; wdata = wd;
        for (int r = 0; r < N; r++)
            exp_rd[r] = re[r] ? mem_m[int'(ad[r*AW +: AW])] : 0;
        exp_v = 1'b0; coll = 1'b0;
        for (int c = 0; c < C; c++) begin
            int wc, rc, first, rot;
            bit eq;
            wc = 0; rc = 0; first = -1; rot = -1; eq = 1'b1;
            exp_mem[c] = mem_m[c];
            for (int r = 0; r < N; r++) begin
                if (re[r] && int'(ad[r*AW +: AW]) == c) rc++;
                if (we[r] && int'(ad[r*AW +: AW]) == c) begin
                    wc++;
                    if (first < 0) first = r;
                end
            end
            for (int r = 0; r < N; r++)
                if (we[r] && int'(ad[r*AW +: AW]) == c && first >= 0 &&
                    wd[r*W +: W] != wd[first*W +: W]) eq = 1'b0;
            for (int k = 0; k < N; k++) begin
                int idx;
                idx = (rr_m + k) % N;
                if (rot < 0 && we[idx] && int'(ad[idx*AW +: AW]) == c) rot = idx;
            end
            case (md)
                0: begin
                    if (rc > 1 || wc > 1) exp_v = 1'b1;
                    if (wc == 1) exp_mem[c] = int'(wd[first*W +: W]);
                end
                1: begin
                    if (wc > 1) exp_v = 1'b1;
                    if (wc == 1) exp_mem[c] = int'(wd[first*W +: W]);
                end
                2: begin
                    if (wc > 0 && eq) exp_mem[c] = int'(wd[first*W +: W]);
                    if (wc > 1 && !eq) exp_v = 1'b1;
                end
                3: begin
                    if (wc > 0) exp_mem[c] = int'(wd[rot*W +: W]);
                    if (wc > 1) coll = 1'b1;
                end
                default: begin
                    if (wc > 0) exp_mem[c] = int'(wd[first*W +: W]);
                end
            endcase
        end
        if (md == 3 && coll) rr_m = (rr_m + 1) % N;
        for (int c = 0; c < C; c++) mem_m[c] = exp_mem[c];
        @(posedge clk);
        #1;
        for (int r = 0; r < N; r++)
            check("R2", int'(rd_data[r*W +: W]), exp_rd[r], "read lane");
        for (int c = 0; c < C; c++)
            check(mtag, int'(mem_out[c*W +: W]), exp_mem[c], "cell value");
        check(mtag, int'(violation), int'(exp_v), "violation flag");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < C; c++) mem_m[c] = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", int'(mem_out), 0, "bank after reset");
        check("R1", int'(rd_data), 0, "read lanes after reset");
        check("R1", int'(violation), 0, "flag after reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R3: lone writer commits in mode 0, then read it back
        step(0, 4'b0000, 4'b0010, 8'b00_00_10_00, 32'h00_00_5A_00, "R3");
        step(0, 4'b0001, 4'b0000, 8'b00_00_00_10, 32'h0, "R3");
        check("R3", int'(rd_data[W-1:0]), 8'h5A, "readback of lone write");

        // R9: mode 6 picks lowest writer
        step(6, 4'b0000, 4'b1100, 8'b01_01_00_00, 32'h33_44_00_00, "R9");
        check("R9", int'(mem_out[1*W +: W]), 8'h44, "mode 6 lowest writer");

        // Sweep over modes, write patterns, read patterns, addresses
        for (int md = 0; md < 8; md++) begin
            for (int we = 0; we < 16; we++) begin
                for (int ri = 0; ri < 4; ri++) begin
                    for (int p = 0; p < 16; p++) begin
                        logic [N-1:0]    re;
                        logic [N*AW-1:0] ad;
                        logic [N*W-1:0]  wd;
                        int base;
                        re = (ri == 0) ? 4'h0 : (ri == 1) ? 4'h1 : (ri == 2) ? 4'h5 : 4'hF;
                        ad = 8'((p * 37 + we * 11 + md) & 8'hFF);
                        base = (p * 7 + we * 3 + md) & 8'hFF;
                        for (int r = 0; r < N; r++)
                            wd[r*W +: W] = (p % 3 == 0) ? 8'(base) : 8'(base + r * 29 + 1);
                        step(md, re, 4'(we), ad, wd, tag_of(md));
                    end
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule